// File: doc/BRIEF.md
# Load/Store Queue Admission and Ordering

This block sits at the dispatch point for memory operations. Each dispatch request is tagged with three flags: may-load, may-store and side-effect. In the same cycle, the block reports whether the operation fits in the load queue and the store queue. The status and ready outputs are combinational and are computed from the occupancy at the start of the cycle. When an operation is accepted, the block gives it an ordering group and names the older group it must wait on. Group 0 means "no dependency". Completion events return queue entries. A configuration input selects between two alias assumptions:

- When the input is low, every load is assumed to alias every older store.
- When the input is high, loads and stores are assumed never to alias.

Group assignment is driven by a small load-group state machine with three states:

- `LG_NONE`: no load group exists yet.
- `LG_OPEN`: the newest load group may still take more plain loads.
- `LG_SEALED`: the newest load group is closed to new loads.

The transitions are:

- NONE→OPEN: a plain load creates a new group.
- OPEN→SEALED: a load barrier is accepted, or a store is accepted while loads are assumed to alias.
- SEALED→OPEN: the next plain load opens a fresh group.
- NONE stays NONE when a sealing event occurs.

Three wait registers hold the newest group that each class of operation must wait on:

| Register | Holds the newest group that… must wait on |
|---|---|
| plain-load wait | a plain load |
| load-barrier wait | a load barrier |
| store wait | any operation that may store |

An operation that neither loads nor stores is always accepted and has no effect on the block. A side-effect operation that may load is a load barrier. A side-effect operation that may store is a store barrier. Because stores already wait on everything older, a store barrier is ordered exactly like a store.

Top module: `lsq_admit`

## Requirements
- R1: A queue whose depth parameter is 0 is unbounded: it never reports full, however many operations it holds.
- R2: `disp_status` uses the following codes:
  - 0: available.
  - 1: load queue full. Reported when the operation may load and the load queue holds its depth.
  - 2: store queue full. Reported when the operation may store, the load-full case does not apply, and the store queue holds its depth.
  - An operation with neither may-load nor may-store always reads 0.
- R3: `disp_ready` is high exactly when the status is 0. A refused operation changes no occupancy and no ordering state, and reads group 0 and dependency 0.
- R4: Queue entries are taken and returned as follows:
  - An accepted operation takes one entry in the load queue if it may load, and one entry in the store queue if it may store. Barriers are included.
  - A completion returns one entry to each queue it flags.
  - A take and a return on the same queue in the same cycle leave the count unchanged.
  - A return to an empty queue is ignored.
- R5: New groups are numbered from 1 to 2^GW−1 in dispatch order and wrap back to 1. After reset the first new group is 1, and all dependencies read 0.
- R6: An accepted operation that may store always opens a new group, and its dependency is the most recently created group.
- R7: A plain load (may-load only, no side effect) accepted while the load group is open joins that group. It reports the group's number and the same dependency that the group's first load reported.
- R8: With `cfg_no_alias` = 0, an accepted store seals the load group. Later plain loads open a new group that depends on that store's group.
- R9: With `cfg_no_alias` = 1, stores neither seal the load group nor become a dependency of later loads.
- R10: A load barrier always opens a new group and depends on the load-barrier wait register. That register holds the newest group that was either a load group or a group that sealed the load group. Younger plain loads then open a new group that depends on the barrier.
- R11: A request with neither may-load nor may-store is always ready, reads group 0 and dependency 0, and leaves every state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_no_alias | input | 1 | 1: loads never alias stores; 0: loads alias all older stores |
| disp_valid | input | 1 | Dispatch request valid |
| disp_may_load | input | 1 | Operation reads memory |
| disp_may_store | input | 1 | Operation writes memory |
| disp_side_effect | input | 1 | Operation has unmodelled side effects (barrier) |
| disp_ready | output | 1 | Request accepted this cycle when valid |
| disp_status | output | 2 | 0 available, 1 load queue full, 2 store queue full |
| disp_group | output | GW | Group given to the accepted operation, else 0 |
| disp_dep | output | GW | Group the accepted operation waits on, 0 for none |
| done_valid | input | 1 | Completion event valid |
| done_load | input | 1 | Completion frees a load-queue entry |
| done_store | input | 1 | Completion frees a store-queue entry |

## Verification
The bench targets the following corner cases:

- **Full-queue priority.** An operation that both loads and stores, arriving with both queues full, must read code 1. A design with the checks in the wrong order would report 2.
- **Same-cycle take and return.** A dispatch with a completion in the same cycle must leave the count unchanged. A design that loses either edge drifts, so a later load is refused one slot early or admitted past the depth.
- **Completion at zero.** A return to an empty queue must be ignored. A design that lets the counter underflow reports the queue as full.
- **Sealing rules.** With aliasing assumed, a load after a store must open a new group. With no-alias set, it must keep joining the old group. Mixing up the two cases moves the dependency to the wrong group.
- **Barriers and wrap-around.** A load after a barrier must open a new group that depends on the barrier. The group counter must skip 0 when it wraps. A counter that reaches 0 would hand out a group number that reads as "no dependency".

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    typedef enum logic [1:0] {
        ST_AVAIL   = 2'd0,
        ST_LQ_FULL = 2'd1,
        ST_SQ_FULL = 2'd2
    } lsq_status_e;

    typedef enum logic [1:0] {
        LG_NONE   = 2'd0,
        LG_OPEN   = 2'd1,
        LG_SEALED = 2'd2
    } lg_state_e;

    typedef struct packed {
        logic ld;
        logic st;
        logic se;
    } mem_op_t;

endpackage

// File: rtl/lsq_occupancy.sv
module lsq_occupancy #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alloc_i,
    input  logic free_i,
    output logic full_o
);
    logic [CW-1:0] used_q;
    logic          free_ok;

    // A return only counts when an entry is actually held (R4)
    assign free_ok = free_i && (used_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
        end else if (alloc_i && !free_ok) begin
            used_q <= used_q + CW'(1);
        end else if (!alloc_i && free_ok) begin
            used_q <= used_q - CW'(1);
        end
    end

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (used_q == $past(used_q)) || (used_q == $past(used_q) + CW'(1))
                 || (used_q == $past(used_q) - CW'(1)));

    generate
        if (DEPTH == 0) begin : g_unbounded
            assign full_o = 1'b0;
        end else begin : g_bounded
            assign full_o = (used_q == CW'(DEPTH));

            a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
                used_q <= CW'(DEPTH));

            a_r3_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rst_n)
                full_o |-> !alloc_i);
        end
    endgenerate

endmodule

// File: rtl/lsq_group_ctr.sv
module lsq_group_ctr #(
    parameter int GW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    output logic [GW-1:0] id_o
);
    localparam logic [GW-1:0] MAX_ID = {GW{1'b1}};

    logic [GW-1:0] id_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= GW'(1);
        end else if (take_i) begin
            id_q <= (id_q == MAX_ID) ? GW'(1) : id_q + GW'(1);
        end
    end

    assign id_o = id_q;

    a_r5_id_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        id_q != '0);

endmodule

// File: rtl/lsq_order.sv
module lsq_order
    import lsq_pkg::*;
#(
    parameter int GW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          no_alias_i,
    input  logic          accept_i,
    input  mem_op_t       op_i,
    input  logic [GW-1:0] new_id_i,
    output logic          take_o,
    output logic [GW-1:0] grp_o,
    output logic [GW-1:0] dep_o
);
    lg_state_e     state_q, state_d;
    logic [GW-1:0] cur_ld_q, cur_ld_d;
    logic [GW-1:0] ld_wait_q, ld_wait_d;
    logic [GW-1:0] lb_wait_q, lb_wait_d;
    logic [GW-1:0] st_wait_q, st_wait_d;
    logic          plain, join_grp, seal_ev, plain_new;

    assign plain     = op_i.ld && !op_i.st && !op_i.se;
    assign join_grp  = plain && (state_q == LG_OPEN);
    assign take_o    = accept_i && !join_grp;
    assign seal_ev   = take_o && ((op_i.st && !no_alias_i) || (op_i.ld && op_i.se));
    assign plain_new = take_o && plain;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LG_NONE;
            cur_ld_q  <= '0;
            ld_wait_q <= '0;
            lb_wait_q <= '0;
            st_wait_q <= '0;
        end else begin
            state_q   <= state_d;
            cur_ld_q  <= cur_ld_d;
            ld_wait_q <= ld_wait_d;
            lb_wait_q <= lb_wait_d;
            st_wait_q <= st_wait_d;
        end
    end

    // Load-group transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LG_NONE:   if (plain_new) state_d = LG_OPEN;
            LG_OPEN:   if (seal_ev)   state_d = LG_SEALED;
            LG_SEALED: if (plain_new) state_d = LG_OPEN;
            default:   state_d = LG_NONE;
        endcase
    end

    // Wait-register updates
    always_comb begin
        cur_ld_d  = cur_ld_q;
        ld_wait_d = ld_wait_q;
        lb_wait_d = lb_wait_q;
        st_wait_d = st_wait_q;
        if (take_o) begin
            st_wait_d = new_id_i;
            if (op_i.ld) lb_wait_d = new_id_i;
            if (op_i.st && !no_alias_i) begin
                ld_wait_d = new_id_i;
                lb_wait_d = new_id_i;
            end
            if (op_i.ld && op_i.se) ld_wait_d = new_id_i;
            if (plain) cur_ld_d = new_id_i;
        end
    end

    // Outputs
    always_comb begin
        grp_o = '0;
        dep_o = '0;
        if (accept_i) begin
            if (join_grp) begin
                grp_o = cur_ld_q;
                dep_o = ld_wait_q;
            end else begin
                grp_o = new_id_i;
                if (op_i.st)      dep_o = st_wait_q;
                else if (op_i.se) dep_o = lb_wait_q;
                else              dep_o = ld_wait_q;
            end
        end
    end

    a_r5_group_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |-> grp_o != '0);

    a_r6_store_waits_newest: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i && op_i.st && $past(rst_n) && $past(take_o) |-> dep_o == $past(grp_o));

    a_r7_load_run_shares_group: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i && plain && $past(rst_n) && $past(accept_i && plain) |-> grp_o == $past(grp_o));

    a_r10_load_after_barrier: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i && plain && $past(rst_n) && $past(accept_i && op_i.ld && op_i.se && !op_i.st)
        |-> (dep_o == $past(grp_o)) && (grp_o != $past(grp_o)));

endmodule

// File: rtl/lsq_admit.sv
module lsq_admit
    import lsq_pkg::*;
#(
    parameter int LQ_DEPTH = 4,
    parameter int SQ_DEPTH = 3,
    parameter int GW       = 4,
    parameter int UNB_W    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_no_alias,
    input  logic          disp_valid,
    input  logic          disp_may_load,
    input  logic          disp_may_store,
    input  logic          disp_side_effect,
    output logic          disp_ready,
    output logic [1:0]    disp_status,
    output logic [GW-1:0] disp_group,
    output logic [GW-1:0] disp_dep,
    input  logic          done_valid,
    input  logic          done_load,
    input  logic          done_store
);
    localparam int LQ_CW = (LQ_DEPTH == 0) ? UNB_W : $clog2(LQ_DEPTH + 1);
    localparam int SQ_CW = (SQ_DEPTH == 0) ? UNB_W : $clog2(SQ_DEPTH + 1);

    mem_op_t       op;
    lsq_status_e   status;
    logic          is_mem, accept, lq_full, sq_full, take;
    logic [GW-1:0] new_id;

    assign op     = '{ld: disp_may_load, st: disp_may_store, se: disp_side_effect};
    assign is_mem = disp_may_load || disp_may_store;

    // Load-full is checked before store-full (R2)
    always_comb begin
        if (!is_mem)                      status = ST_AVAIL;
        else if (op.ld && lq_full)        status = ST_LQ_FULL;
        else if (op.st && sq_full)        status = ST_SQ_FULL;
        else                              status = ST_AVAIL;
    end

    assign disp_status = status;
    assign disp_ready  = (status == ST_AVAIL);
    assign accept      = disp_valid && disp_ready && is_mem;

    lsq_occupancy #(.DEPTH(LQ_DEPTH), .CW(LQ_CW)) u_lq (
        .clk(clk), .rst_n(rst_n),
        .alloc_i(accept && op.ld),
        .free_i(done_valid && done_load),
        .full_o(lq_full)
    );

    lsq_occupancy #(.DEPTH(SQ_DEPTH), .CW(SQ_CW)) u_sq (
        .clk(clk), .rst_n(rst_n),
        .alloc_i(accept && op.st),
        .free_i(done_valid && done_store),
        .full_o(sq_full)
    );

    lsq_group_ctr #(.GW(GW)) u_ids (
        .clk(clk), .rst_n(rst_n),
        .take_i(take),
        .id_o(new_id)
    );

    lsq_order #(.GW(GW)) u_ord (
        .clk(clk), .rst_n(rst_n),
        .no_alias_i(cfg_no_alias),
        .accept_i(accept),
        .op_i(op),
        .new_id_i(new_id),
        .take_o(take),
        .grp_o(disp_group),
        .dep_o(disp_dep)
    );

    a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        disp_status != 2'd3);

    a_r11_nonmem_no_group: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && !disp_may_load && !disp_may_store
        |-> disp_ready && (disp_group == '0) && (disp_dep == '0));

endmodule

// File: tb/sim_lsq_admit.sv
module sim_lsq_admit;
    localparam int LQD = 4;
    localparam int SQD = 3;
    localparam int GW  = 4;
    localparam int MAXID = (1 << GW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic na = 1'b0, v = 1'b0, ld = 1'b0, st = 1'b0, se = 1'b0;
    logic dv = 1'b0, dl = 1'b0, ds = 1'b0;
    logic          rdy, rdy1;
    logic [1:0]    sts, sts1;
    logic [GW-1:0] grp, dep, grp1, dep1;

    int checks = 0, errors = 0;
    string tag = "R5";
    int lq = 0, sq = 0, nid = 1, ldw = 0, lbw = 0, stw = 0, curld = 0;
    bit open_f = 0;

    always #2 clk = ~clk;

    lsq_admit #(.LQ_DEPTH(LQD), .SQ_DEPTH(SQD), .GW(GW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_no_alias(na),
        .disp_valid(v), .disp_may_load(ld), .disp_may_store(st), .disp_side_effect(se),
        .disp_ready(rdy), .disp_status(sts), .disp_group(grp), .disp_dep(dep),
        .done_valid(dv), .done_load(dl), .done_store(ds));

    lsq_admit #(.LQ_DEPTH(0), .SQ_DEPTH(0), .GW(GW)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_no_alias(na),
        .disp_valid(v), .disp_may_load(ld), .disp_may_store(st), .disp_side_effect(se),
        .disp_ready(rdy1), .disp_status(sts1), .disp_group(grp1), .disp_dep(dep1),
        .done_valid(dv), .done_load(dl), .done_store(ds));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input bit iv, input bit il, input bit is, input bit ie,
                        input bit idv, input bit idl, input bit ids);
        int es, eg, ed;
        bit mem, acc, plain;
        @(negedge clk);
        v = iv; ld = il; st = is; se = ie; dv = idv; dl = idl; ds = ids;
        #1;
        mem = il || is;
        es = 0;
        if (mem) begin
            if (il && lq == LQD)      es = 1;
            else if (is && sq == SQD) es = 2;
        end
        acc = iv && (es == 0) && mem;
        plain = il && !is && !ie;
        eg = 0; ed = 0;
        if (acc) begin
            if (plain && open_f) begin
                eg = curld; ed = ldw;
            end else begin
                eg = nid;
                ed = is ? stw : (ie ? lbw : ldw);
                nid = (nid == MAXID) ? 1 : nid + 1;
                stw = eg;
                if (il) lbw = eg;
                if (is && !na) begin ldw = eg; lbw = eg; open_f = 0; end
                if (il && ie) begin ldw = eg; open_f = 0; end
                if (plain) begin curld = eg; open_f = 1; end
            end
        end
        chk((tag == "R4") ? "R4" : "R2", "status", int'(sts), es);
        chk("R3", "ready", int'(rdy), (es == 0) ? 1 : 0);
        chk(tag, "group", int'(grp), eg);
        chk(tag, "dep", int'(dep), ed);
        if (iv && mem) chk("R1", "unbounded status", int'(sts1), 0);
        lq = lq + ((acc && il) ? 1 : 0) - ((idv && idl && lq != 0) ? 1 : 0);
        sq = sq + ((acc && is) ? 1 : 0) - ((idv && ids && sq != 0) ? 1 : 0);
    endtask

    task automatic free_all();
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 1, 1);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R5: reset state, first group 1, no dependency
        tag = "R5";
        step(0, 0, 0, 0, 0, 0, 0);
        // R11: non-memory operations
        tag = "R11";
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0);
        // R7: loads share one group
        tag = "R7";
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        // R8: aliasing store seals, next load waits on it
        tag = "R8";
        step(1, 0, 1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        tag = "R7";
        step(1, 1, 0, 0, 0, 0, 0);
        // R2: load queue full, then store queue full, then priority
        tag = "R2";
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0);
        step(1, 1, 1, 0, 0, 0, 0);
        // R4: same-cycle take and return, and return at zero
        tag = "R4";
        step(0, 0, 0, 0, 1, 1, 0);
        step(1, 1, 0, 0, 1, 1, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        free_all();
        step(1, 1, 1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        free_all();
        // R9: no-alias keeps load group open across stores
        na = 1'b1;
        tag = "R9";
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 1, 1, 1);
        free_all();
        // R10: load barriers
        na = 1'b0;
        tag = "R10";
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 1, 0, 0, 0);
        free_all();
        // R6: stores and store barriers chain
        tag = "R6";
        step(1, 0, 1, 0, 0, 0, 0);
        step(1, 0, 1, 1, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0);
        free_all();
        // R5: group counter wrap
        tag = "R5";
        for (int i = 0; i < 20; i++) step(1, 0, 1, 0, 1, 0, 1);
        free_all();
        // R1: unbounded instance never full
        tag = "R1";
        for (int i = 0; i < 8; i++) step(1, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) step(1, 0, 1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule